// File: doc/BRIEF.md
# Register-Triggered Bus Access Proxy

The block sits on a register bus as a small slave and lets software perform one single-beat read or write on a separate master bus while presenting someone else's identity. Software loads a target address and a data word, then writes a control word. That control write starts the access. The control word chooses read or write, the byte lanes, a two-bit security/path selector, nine request-info sideband bits and the six-bit master ID to impersonate.

A write goes out with the data register as its payload. A read brings the returned word back into the data register. Software usually stores a sentinel value in the data register before it starts a read, then polls until that value changes. A disable input suppresses reads: a read launched while it is high completes at once with no bus activity. The `busy` output is high while an access is outstanding. Control writes that arrive during that time are dropped.

On reads, byte-enable bit 1 also sets the address alignment. When it is clear, the low four address bits are forced to zero, so the read is aligned to 16 bytes. When it is set, the address goes out unchanged.

Top module: `bus_proxy`

## Requirements
- R1: The slave register at byte offset 0x0 is the address, 0x4 is the data word and 0x8 is the control word. Each reads back what was written. Any other offset reads zero and ignores writes.
- R2: A control write while idle makes `m_req_valid` rise after that clock edge. Exactly one request is issued. `m_req_write` equals control bit 0 (1 = write) and `m_req_wdata` equals the data register.
- R3: Each request carries the following fields from the control word. Control bits 6:3 drive `m_req_strb[3:0]` (bit 3 drives lane 0). Bits 30:25 drive `m_req_mid`. Bits 15:7 drive `m_req_info[8:0]`. Bits 2:1 drive `m_req_sel`.
- R4: A write request carries the address register unchanged. A read request carries the address with bits 3:0 cleared when control bit 4 is 0, and the address unchanged when bit 4 is 1.
- R5: While `m_req_valid` is high and `m_req_ready` is low, the request and all its fields hold steady.
- R6: Suppose `m_rsp_valid` is seen on a clock edge while a read is waiting. After that edge, the data register holds `m_rsp_rdata` and `busy` is low.
- R7: `busy` is high from the edge after a launch to the edge that takes the response. A control write during that time leaves the control register unchanged and issues no request.
- R8: Control bit 31 always reads zero.
- R9: With `rd_disable` high, a launched read raises neither `m_req_valid` nor `busy`, and the data register is left unchanged. The control word is still stored. Writes are not affected.
- R10: Reset clears the address, data and control registers to zero and drops `busy` and `m_req_valid`.
- R11: Completion of a write leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_wr_en | input | 1 | Register write strobe |
| s_offs | input | 4 | Register byte offset |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data for `s_offs` (combinational) |
| rd_disable | input | 1 | Suppresses read accesses |
| busy | output | 1 | Access outstanding |
| m_req_valid | output | 1 | Master request valid |
| m_req_ready | input | 1 | Master request accepted |
| m_req_write | output | 1 | 1 = write, 0 = read |
| m_req_addr | output | 32 | Target address |
| m_req_wdata | output | 32 | Write payload |
| m_req_strb | output | 4 | Byte lane enables |
| m_req_mid | output | 6 | Impersonated master ID |
| m_req_info | output | 9 | Request-info sideband (control bits 15:7) |
| m_req_sel | output | 2 | Security/path selector (0 secure, 1 alternate, 2 non-secure) |
| m_rsp_valid | input | 1 | Response valid |
| m_rsp_rdata | input | 32 | Response read data |

## Verification
Register writes show up on `s_rdata` one edge later. A launch raises `m_req_valid` and `busy` on the edge that takes the control write. The request drops on the edge where `m_req_ready` is high. A read's returned word and the fall of `busy` appear on the edge that sees `m_rsp_valid`. The bench steps a behavioural model on the same edges, using only the signals the bench itself drives. It compares every output half a period after each edge, once all those registered changes have settled. The target model varies its acceptance stall and response latency, so the hold and wait cases come up at several different distances.

// File: rtl/bus_proxy_pkg.sv
package bus_proxy_pkg;
    localparam int WORD_W = 32;
    localparam int OFFS_W = 4;
    localparam int MID_W  = 6;
    localparam int INFO_W = 9;
    localparam int SEL_W  = 2;
    localparam int STRB_W = WORD_W / 8;

    localparam logic [OFFS_W-1:0] OFF_ADDR = 4'h0;
    localparam logic [OFFS_W-1:0] OFF_DATA = 4'h4;
    localparam logic [OFFS_W-1:0] OFF_CTRL = 4'h8;

    localparam int CB_WRITE  = 0;
    localparam int CB_SEL_LO = 1;
    localparam int CB_BE_LO  = 3;
    localparam int CB_NOALGN = 4;
    localparam int CB_INFO_LO = 7;
    localparam int CB_MID_LO = 25;
    localparam int CB_RAZ    = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic              write;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [STRB_W-1:0] strb;
        logic [MID_W-1:0]  mid;
        logic [INFO_W-1:0] info;
        logic [SEL_W-1:0]  sel;
    } bus_req_t;
endpackage

// File: rtl/bus_proxy_regs.sv
module bus_proxy_regs
    import bus_proxy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] offs,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              launch_ok,
    input  logic              rd_done,
    input  logic [WORD_W-1:0] rd_data,
    output logic              launch,
    output logic [WORD_W-1:0] launch_ctrl,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o
);
    localparam logic [WORD_W-1:0] CTRL_MASK = ~(WORD_W'(1) << CB_RAZ);

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] ctrl;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        launch_ctrl = wdata & CTRL_MASK;
        launch      = wr_en && (offs == OFF_CTRL) && launch_ok;
        if (wr_en && offs == OFF_ADDR) r_d.addr = wdata;
        if (wr_en && offs == OFF_DATA) r_d.data = wdata;
        if (launch)                    r_d.ctrl = launch_ctrl;
        if (rd_done)                   r_d.data = rd_data;
        unique case (offs)
            OFF_ADDR: rdata = r_q.addr;
            OFF_DATA: rdata = r_q.data;
            OFF_CTRL: rdata = r_q.ctrl;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_o = r_q.addr;
    assign data_o = r_q.data;

    p_ctrl_kept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offs == OFF_CTRL && !launch_ok) |=> $stable(r_q.ctrl));
    p_read_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (r_q.data == $past(rd_data)));
    p_addr_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offs == OFF_ADDR) |=> (addr_o == $past(wdata)));
endmodule

// File: rtl/bus_proxy_launch.sv
module bus_proxy_launch
    import bus_proxy_pkg::*;
#(
    parameter int ALIGN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [WORD_W-1:0] launch_ctrl,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    input  logic              rd_disable,
    output logic              idle,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output bus_req_t          req,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_rdata,
    output logic              rd_done,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [WORD_W-1:0] ALIGN_MASK = ~((WORD_W'(1) << ALIGN_LSB) - WORD_W'(1));

    typedef struct packed {
        xfer_state_e st;
        bus_req_t    req;
    } lch_t;

    lch_t l_q, l_d;
    logic is_wr, rd_blocked;

    always_comb begin
        l_d        = l_q;
        rd_done    = 1'b0;
        rd_data    = rsp_rdata;
        is_wr      = launch_ctrl[CB_WRITE];
        rd_blocked = !is_wr && rd_disable;
        unique case (l_q.st)
            ST_IDLE: begin
                if (launch && !rd_blocked) begin
                    l_d.st        = ST_REQ;
                    l_d.req.write = is_wr;
                    l_d.req.addr  = (is_wr || launch_ctrl[CB_NOALGN]) ? addr : (addr & ALIGN_MASK);
                    l_d.req.wdata = data;
                    l_d.req.strb  = launch_ctrl[CB_BE_LO +: STRB_W];
                    l_d.req.mid   = launch_ctrl[CB_MID_LO +: MID_W];
                    l_d.req.info  = launch_ctrl[CB_INFO_LO +: INFO_W];
                    l_d.req.sel   = launch_ctrl[CB_SEL_LO +: SEL_W];
                end
            end
            ST_REQ: begin
                if (req_ready) l_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    l_d.st  = ST_IDLE;
                    rd_done = !l_q.req.write;
                end
            end
            default: l_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '{st: ST_IDLE, req: '0};
        else        l_q <= l_d;
    end

    assign idle      = (l_q.st == ST_IDLE);
    assign busy      = !idle;
    assign req_valid = (l_q.st == ST_REQ);
    assign req       = l_q.req;

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req)));
    p_req_from_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(launch));
    p_disabled_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !launch_ctrl[CB_WRITE] && rd_disable) |=> !busy);
    p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_valid && rsp_valid) |=> !busy);
endmodule

// File: rtl/bus_proxy.sv
module bus_proxy
    import bus_proxy_pkg::*;
#(
    parameter int ALIGN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_wr_en,
    input  logic [OFFS_W-1:0] s_offs,
    input  logic [WORD_W-1:0] s_wdata,
    output logic [WORD_W-1:0] s_rdata,
    input  logic              rd_disable,
    output logic              busy,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [WORD_W-1:0] m_req_addr,
    output logic [WORD_W-1:0] m_req_wdata,
    output logic [STRB_W-1:0] m_req_strb,
    output logic [MID_W-1:0]  m_req_mid,
    output logic [INFO_W-1:0] m_req_info,
    output logic [SEL_W-1:0]  m_req_sel,
    input  logic              m_rsp_valid,
    input  logic [WORD_W-1:0] m_rsp_rdata
);
    logic              launch, idle, rd_done;
    logic [WORD_W-1:0] launch_ctrl, addr_w, data_w, rd_data;
    bus_req_t          req;

    bus_proxy_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .offs(s_offs), .wdata(s_wdata),
        .rdata(s_rdata), .launch_ok(idle), .rd_done(rd_done), .rd_data(rd_data),
        .launch(launch), .launch_ctrl(launch_ctrl), .addr_o(addr_w), .data_o(data_w)
    );

    bus_proxy_launch #(.ALIGN_LSB(ALIGN_LSB)) u_launch (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_ctrl(launch_ctrl),
        .addr(addr_w), .data(data_w), .rd_disable(rd_disable), .idle(idle),
        .busy(busy), .req_valid(m_req_valid), .req_ready(m_req_ready), .req(req),
        .rsp_valid(m_rsp_valid), .rsp_rdata(m_rsp_rdata), .rd_done(rd_done),
        .rd_data(rd_data)
    );

    assign m_req_write = req.write;
    assign m_req_addr  = req.addr;
    assign m_req_wdata = req.wdata;
    assign m_req_strb  = req.strb;
    assign m_req_mid   = req.mid;
    assign m_req_info  = req.info;
    assign m_req_sel   = req.sel;

    p_reset_quiet_r10: assert property (@(posedge clk) $rose(rst_n) |-> (!busy && !m_req_valid));
endmodule

// File: tb/bus_proxy_bench.sv
module bus_proxy_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 20000;
    localparam logic [31:0] KEY = 32'hA5A5_0F0F;
    localparam logic [31:0] SENT = 32'hDEADBABE;

    logic        clk = 0, rst_n = 0;
    logic        s_wr_en = 0;
    logic [3:0]  s_offs = 0;
    logic [31:0] s_wdata = 0, s_rdata;
    logic        rd_disable = 0, busy;
    logic        m_req_valid, m_req_ready = 0, m_req_write;
    logic [31:0] m_req_addr, m_req_wdata;
    logic [3:0]  m_req_strb;
    logic [5:0]  m_req_mid;
    logic [8:0]  m_req_info;
    logic [1:0]  m_req_sel;
    logic        m_rsp_valid = 0;
    logic [31:0] m_rsp_rdata = 0;

    int checks = 0, errors = 0, cycles = 0;
    int stall_len = 0, rsp_lat = 1, wait_cnt = 0, pend = 0;
    logic [31:0] pend_data = 0;

    // reference model state
    logic [31:0] ma = 0, md = 0, mc = 0, mq_addr = 0, mq_wdata = 0;
    int          mst = 0;
    logic        mq_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_proxy u_bus_proxy (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rd(logic [3:0] o);
        case (o)
            4'h0: return ma;
            4'h4: return md;
            4'h8: return mc;
            default: return 32'h0;
        endcase
    endfunction

    // behavioural model, stepped on the clock edge from bench-driven inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ma = 0; md = 0; mc = 0; mst = 0;
        end else begin
            logic [31:0] nd;
            nd = md;
            if (s_wr_en && s_offs == 4'h0) ma = s_wdata;
            if (s_wr_en && s_offs == 4'h4) nd = s_wdata;
            if (mst == 2 && m_rsp_valid) begin
                mst = 0;
                if (!mq_wr) nd = m_rsp_rdata;
            end else if (mst == 1 && m_req_ready) begin
                mst = 2;
            end else if (mst == 0 && s_wr_en && s_offs == 4'h8) begin
                mc = s_wdata & 32'h7FFF_FFFF;
                if (s_wdata[0] || !rd_disable) begin
                    mst = 1;
                    mq_wr = s_wdata[0];
                    mq_wdata = md;
                    mq_addr = (s_wdata[0] || s_wdata[4]) ? ma : {ma[31:4], 4'h0};
                end
            end
            md = nd;
        end
    end

    // comparison and target model, half a period after each edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rst_n) begin
            chk("R1 register read", s_rdata, m_rd(s_offs));
            chk("R7 busy", {31'b0, busy}, {31'b0, mst != 0});
            chk("R2 request valid", {31'b0, m_req_valid}, {31'b0, mst == 1});
            if (mst == 1) begin
                chk("R2 request kind", {31'b0, m_req_write}, {31'b0, mq_wr});
                chk("R2 request data", m_req_wdata, mq_wdata);
                chk("R4 request address", m_req_addr, mq_addr);
                chk("R3 strobes", {28'b0, m_req_strb}, {28'b0, mc[6:3]});
                chk("R3 master id", {26'b0, m_req_mid}, {26'b0, mc[30:25]});
                chk("R3 info", {23'b0, m_req_info}, {23'b0, mc[15:7]});
                chk("R3 selector", {30'b0, m_req_sel}, {30'b0, mc[2:1]});
            end
            if (m_rsp_valid) m_rsp_valid = 0;
            else if (pend > 0) begin
                pend--;
                if (pend == 0) begin m_rsp_valid = 1; m_rsp_rdata = pend_data; end
            end
            if (m_req_ready) begin
                m_req_ready = 0;
                pend = rsp_lat;
            end else if (m_req_valid) begin
                if (wait_cnt == 0) begin
                    m_req_ready = 1;
                    pend_data = m_req_addr ^ KEY;
                    wait_cnt = stall_len;
                end else wait_cnt--;
            end
        end else begin
            m_req_ready = 0; m_rsp_valid = 0; pend = 0; wait_cnt = stall_len;
        end
    end

    task automatic wr(logic [3:0] o, logic [31:0] v);
        @(posedge clk); #1;
        s_wr_en = 1; s_offs = o; s_wdata = v;
        @(posedge clk); #1;
        s_wr_en = 0;
    endtask

    task automatic peek(logic [3:0] o, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        s_offs = o;
        @(negedge clk);
        chk(tag, s_rdata, exp);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wait_req();
        @(negedge clk);
        while (!m_req_valid) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10: state after reset
        peek(4'h0, 32'h0, "R10 address zero");
        peek(4'h4, 32'h0, "R10 data zero");
        peek(4'h8, 32'h0, "R10 control zero");
        chk("R10 idle", {31'b0, busy}, 32'h0);

        // R4/R6: aligned read, sentinel polling
        stall_len = 2; rsp_lat = 3;
        wr(4'h0, 32'h1000_0123);
        wr(4'h4, SENT);
        wr(4'h8, 32'h0000_0000);
        peek(4'h4, SENT, "R6 sentinel before reply");
        wait_idle();
        peek(4'h4, 32'h1000_0120 ^ KEY, "R6 aligned read reply");

        // R3/R4: unaligned read with impersonation fields
        stall_len = 0; rsp_lat = 1;
        wr(4'h8, (32'h2A << 25) | (32'h155 << 7) | (32'h2 << 1) | (32'h1 << 4));
        wait_req();
        chk("R4 unaligned address", m_req_addr, 32'h1000_0123);
        chk("R3 master id 0x2A", {26'b0, m_req_mid}, 32'h2A);
        wait_idle();
        peek(4'h4, 32'h1000_0123 ^ KEY, "R6 unaligned read reply");

        // R2/R3/R11: write with partial lanes
        stall_len = 3; rsp_lat = 2;
        wr(4'h0, 32'h2000_0007);
        wr(4'h4, 32'h1122_3344);
        wr(4'h8, 32'h1 | (32'h5 << 3) | (32'h15 << 25) | (32'h1 << 1));
        wait_req();
        chk("R3 strobes 0101", {28'b0, m_req_strb}, 32'h5);
        chk("R4 write address not aligned", m_req_addr, 32'h2000_0007);
        chk("R5 held while stalled", m_req_wdata, 32'h1122_3344);
        wait_idle();
        peek(4'h4, 32'h1122_3344, "R11 data kept after write");

        // R7: control write while busy is dropped
        stall_len = 5; rsp_lat = 4;
        wr(4'h8, 32'h0000_0010);
        wr(4'h8, 32'hFFFF_FFFF);
        chk("R7 busy during access", {31'b0, busy}, 32'h1);
        peek(4'h8, 32'h0000_0010, "R7 control unchanged");
        wait_idle();

        // R8/R9: disabled read
        rd_disable = 1;
        wr(4'h4, SENT);
        wr(4'h8, 32'hFFFF_FFFE);
        chk("R9 no busy on disabled read", {31'b0, busy}, 32'h0);
        chk("R9 no request", {31'b0, m_req_valid}, 32'h0);
        peek(4'h8, 32'h7FFF_FFFE, "R8 top bit reads zero");
        peek(4'h4, SENT, "R9 data unchanged");
        // R9: write still goes out
        stall_len = 0; rsp_lat = 1;
        wr(4'h8, 32'h0000_0079);
        wait_req();
        chk("R9 write proceeds when disabled", {31'b0, m_req_write}, 32'h1);
        wait_idle();
        rd_disable = 0;

        // R1: unmapped offset
        wr(4'hC, 32'h1234_5678);
        peek(4'hC, 32'h0, "R1 unmapped offset");

        // R10: reset during an access
        stall_len = 6;
        wr(4'h8, 32'h0000_0000);
        @(posedge clk); #1 rst_n = 0;
        @(negedge clk);
        chk("R10 busy cleared", {31'b0, busy}, 32'h0);
        chk("R10 valid cleared", {31'b0, m_req_valid}, 32'h0);
        @(posedge clk); #1 rst_n = 1;
        peek(4'h0, 32'h0, "R10 address cleared");
        peek(4'h4, 32'h0, "R10 data cleared");

        repeat (3) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule